// File: doc/BRIEF.md
# Cartridge ROM/RAM bank controller

This block maps the 16-bit address space of an 8-bit processor onto a cartridge that holds far more ROM than the processor can see at once, plus an optional external RAM without battery backup. Writes aimed at the read-only region do not reach any memory. Instead they update a small set of control registers: a RAM enable, a lower ROM bank number, a 2-bit upper-bank field, and a banking mode bit.

On every cycle the block turns the current bus address into a physical ROM address and a physical RAM address. It raises the RAM chip-select and write-enable only when the RAM window is accessed, RAM is enabled and RAM is fitted. When a RAM-window read cannot be served, it raises a flag and supplies the constant byte 0xFF for the bus to return. The ROM and RAM arrays sit outside the block. Two static configuration inputs give the fitted ROM size and RAM size.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the lower ROM bank is 1, RAM is disabled, the upper-bank field is 0 and the mode is simple. As a result, a read of 0x4000 gives ROM address 0x4000, and a RAM-window read raises the 0xFF flag.
- R2: A write in 0x0000–0x1FFF enables RAM when the low nibble of the data is 0xA. Any other low nibble disables RAM.
- R3: A write in 0x2000–0x3FFF loads data bits [4:0] into the lower ROM bank. If those bits are zero, 1 is stored instead.
- R4: A write in 0x4000–0x5FFF loads data bits [1:0] into the upper-bank field.
- R5: A write in 0x6000–0x7FFF with data 0x01 selects advanced mode, and data 0x00 selects simple mode. Every other value leaves the mode unchanged.
- R6: A read in 0x0000–0x3FFF gives ROM address A in simple mode, and A + upper×0x80000 in advanced mode.
- R7: A read in 0x4000–0x7FFF gives ROM address (A−0x4000) + lower×0x4000 + upper×0x80000.
- R8: Every ROM address is reduced modulo the ROM length. Size code k (0..6) means 2^(k+1) banks of 16 KiB. Code 7 is treated as 6.
- R9: In the RAM window 0xA000–0xBFFF, the RAM address is (A−0xA000) in simple mode and (A−0xA000) + upper×0x2000 in advanced mode, reduced modulo the RAM size. RAM size codes are: 0 none, 1 2 KiB, 2 8 KiB, 3 32 KiB, 4 64 KiB, 5 128 KiB, 6 and 7 none.
- R10: When RAM is disabled or not fitted, a RAM-window read raises `fill_valid` with `fill_data` = 0xFF, and a RAM-window access asserts neither `ram_cs` nor `ram_we`.
- R11: `ram_cs` is high for a RAM-window read or write while RAM is enabled and fitted. `ram_we` is high only when such an access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Bus write data |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| rom_size_sel | input | 3 | ROM size code (R8) |
| ram_size_sel | input | 3 | RAM size code (R9) |
| rom_addr | output | 21 | Physical ROM address |
| ram_addr | output | 17 | Physical RAM address |
| ram_cs | output | 1 | External RAM chip-select |
| ram_we | output | 1 | External RAM write-enable |
| fill_valid | output | 1 | A RAM-window read is answered by the block |
| fill_data | output | 8 | Byte returned when fill_valid is high (0xFF) |

## Verification
The address translation is tried in several ways:
- with reads at both edges of each window, to show that the window decode and the offset bits are correct;
- with bank writes of zero, of a value that is zero only after masking, and of a value with set bits above the field, to separate the zero substitution from the masking;
- in both modes with a non-zero upper field, to show where that field is applied in the fixed window, the switchable window and RAM;
- over every ROM and RAM size code with a large bank setting, to show the modulo wrap and the "no RAM" handling.

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int LO_W      = 5,
  parameter int HI_W      = 2,
  parameter int ROM_OFS_W = 14,
  parameter int RAM_OFS_W = 13,
  parameter int RAM_AW    = 17,
  localparam int ROM_AW   = HI_W + LO_W + ROM_OFS_W,
  localparam int RAM_MW   = HI_W + RAM_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [2:0]        rom_size_sel,
  input  logic [2:0]        ram_size_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic              fill_valid,
  output logic [7:0]        fill_data
);

  logic [LO_W-1:0] lo_bank;
  logic [HI_W-1:0] hi_field;
  logic            ram_en;
  logic            adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_bank  <= LO_W'(1);
      hi_field <= '0;
      ram_en   <= 1'b0;
      adv      <= 1'b0;
    end else if (cpu_wr && !cpu_addr[15]) begin
      case (cpu_addr[14:13])
        2'd0: ram_en <= (cpu_wdata[3:0] == 4'hA);
        2'd1: lo_bank <= (cpu_wdata[LO_W-1:0] == '0) ? LO_W'(1) : cpu_wdata[LO_W-1:0];
        2'd2: hi_field <= cpu_wdata[HI_W-1:0];
        default: begin
          if (cpu_wdata == 8'h01)      adv <= 1'b1;
          else if (cpu_wdata == 8'h00) adv <= 1'b0;
        end
      endcase
    end
  end

  logic [4:0]        rom_bits;
  logic [4:0]        ram_bits;
  logic [ROM_AW-1:0] rom_raw;
  logic [RAM_MW-1:0] ram_map;
  logic [HI_W-1:0]   hi_eff;
  logic              ram_win;
  logic              ram_live;

  assign rom_bits = (rom_size_sel > 3'd6) ? 5'd21 : 5'd15 + {2'b00, rom_size_sel};

  always_comb begin
    case (ram_size_sel)
      3'd1:    ram_bits = 5'd11;
      3'd2:    ram_bits = 5'd13;
      3'd3:    ram_bits = 5'd15;
      3'd4:    ram_bits = 5'd16;
      3'd5:    ram_bits = 5'd17;
      default: ram_bits = 5'd0;
    endcase
  end

  assign hi_eff  = adv ? hi_field : '0;
  assign rom_raw = cpu_addr[14] ? {hi_field, lo_bank, cpu_addr[ROM_OFS_W-1:0]}
                                : {hi_eff, {LO_W{1'b0}}, cpu_addr[ROM_OFS_W-1:0]};
  assign rom_addr = rom_raw & ~({ROM_AW{1'b1}} << rom_bits);

  assign ram_map  = {hi_eff, cpu_addr[RAM_OFS_W-1:0]};
  assign ram_addr = RAM_AW'(ram_map) & ~({RAM_AW{1'b1}} << ram_bits);

  assign ram_win    = (cpu_addr[15:13] == 3'b101);
  assign ram_live   = ram_en && (ram_bits != 5'd0);
  assign ram_cs     = ram_win && ram_live && (cpu_rd || cpu_wr);
  assign ram_we     = ram_win && ram_live && cpu_wr;
  assign fill_valid = ram_win && !ram_live && cpu_rd;
  assign fill_data  = 8'hFF;

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
  parameter int LO_W   = 5,
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [2:0]        rom_size_sel,
  input logic [2:0]        ram_size_sel,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_cs,
  input logic              ram_we,
  input logic              fill_valid,
  input logic [LO_W-1:0]   lo_bank,
  input logic              adv
);

  int rom_span;
  assign rom_span = (rom_size_sel > 3'd6) ? 21 : 15 + int'(rom_size_sel);

  // R3
  lo_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata[LO_W-1:0] == '0) |=> (lo_bank == LO_W'(1)));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011 && cpu_wdata > 8'h01) |=> $stable(adv));

  // R2
  ram_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA) |=> !ram_cs);

  // R8
  rom_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15] == 1'b0) |-> ((32'(rom_addr) >> rom_span) == 0));

  // R10
  ram_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, fill_valid}));

  // R11
  ram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && ram_cs && cpu_addr[15:13] == 3'b101));

  // R9
  ram_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_size_sel == 3'd0 || ram_size_sel > 3'd5) |-> !ram_cs);

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.LO_W(LO_W), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_chk (.*);

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [2:0]  rom_size_sel = 3'd6;
  logic [2:0]  ram_size_sel = 3'd5;
  logic [20:0] rom_addr;
  logic [16:0] ram_addr;
  logic        ram_cs, ram_we, fill_valid;
  logic [7:0]  fill_data;

  cart_bank_ctrl i_cart_bank_ctrl (.*);

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  int m_lo, m_hi, m_en, m_adv;

  task automatic check(string tag, longint got, longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: addr=%h got %0h expected %0h", tag, cpu_addr, got, exp);
    end
  endtask

  function automatic longint rom_len();
    int k = (rom_size_sel > 3'd6) ? 6 : int'(rom_size_sel);
    return longint'(2 << k) * 16384;
  endfunction

  function automatic longint ram_len();
    case (ram_size_sel)
      3'd1: return 2048;
      3'd2: return 8192;
      3'd3: return 32768;
      3'd4: return 65536;
      3'd5: return 131072;
      default: return 0;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0;
    m_lo = 1; m_hi = 0; m_en = 0; m_adv = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic cyc(string tag, int a, int d, bit wr, bit rd);
    longint er, eram;
    bit win, live;
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = wr; cpu_rd = rd;
    @(negedge clk);
    if (a < 16'h4000)      er = a + (m_adv ? longint'(m_hi) * 524288 : 0);
    else                   er = (a - 16'h4000) + longint'(m_lo) * 16384 + longint'(m_hi) * 524288;
    er = er % rom_len();
    win  = (a >= 16'hA000 && a < 16'hC000);
    live = (m_en != 0) && (ram_len() != 0);
    if (a < 16'h8000) check({tag, " R6/R7/R8 rom_addr"}, rom_addr, er);
    check({tag, " R11 ram_cs"}, ram_cs, win && live && (rd || wr));
    check({tag, " R11 ram_we"}, ram_we, win && live && wr);
    check({tag, " R10 fill_valid"}, fill_valid, win && !live && rd);
    if (win && !live && rd) check({tag, " R10 fill_data"}, fill_data, 8'hFF);
    if (win && live) begin
      eram = ((a - 16'hA000) + (m_adv ? longint'(m_hi) * 8192 : 0)) % ram_len();
      check({tag, " R9 ram_addr"}, ram_addr, eram);
    end
    @(posedge clk);
    if (wr && a < 16'h8000) begin
      if (a < 16'h2000)      m_en = ((d & 15) == 10);
      else if (a < 16'h4000) m_lo = ((d & 31) == 0) ? 1 : (d & 31);
      else if (a < 16'h6000) m_hi = d & 3;
      else if (d == 1)       m_adv = 1;
      else if (d == 0)       m_adv = 0;
    end
    #1;
  endtask

  initial begin
    do_reset();
    cyc("R1 reset rom", 16'h4000, 0, 0, 1);
    cyc("R1 reset ram", 16'hA000, 0, 0, 1);
    cyc("R1 reset fixed", 16'h3FFF, 0, 0, 1);

    cyc("R2 enable", 16'h0000, 8'h0A, 1, 0);
    cyc("R2 read", 16'hA123, 0, 0, 1);
    cyc("R11 write", 16'hBFFF, 8'h55, 1, 0);
    cyc("R11 idle", 16'hB000, 0, 0, 0);
    cyc("R2 disable", 16'h1FFF, 8'h0B, 1, 0);
    cyc("R2 off read", 16'hA000, 0, 0, 1);
    cyc("R10 off write", 16'hA000, 8'h12, 1, 0);
    cyc("R2 nibble", 16'h1000, 8'hFA, 1, 0);
    cyc("R2 on again", 16'hA001, 0, 0, 1);

    cyc("R3 zero", 16'h2000, 8'h00, 1, 0);
    cyc("R3 rd", 16'h4000, 0, 0, 1);
    cyc("R3 masked zero", 16'h2345, 8'h20, 1, 0);
    cyc("R3 rd", 16'h7FFF, 0, 0, 1);
    cyc("R3 max", 16'h3FFF, 8'h1F, 1, 0);
    cyc("R3 rd", 16'h5555, 0, 0, 1);
    cyc("R3 mask", 16'h2100, 8'hE5, 1, 0);
    cyc("R7 rd", 16'h4001, 0, 0, 1);

    cyc("R4 upper", 16'h4000, 8'h03, 1, 0);
    cyc("R7 rd", 16'h7FFF, 0, 0, 1);
    cyc("R6 simple", 16'h0123, 0, 0, 1);
    cyc("R9 simple", 16'hA456, 0, 0, 1);
    cyc("R4 upper mask", 16'h5FFF, 8'hFE, 1, 0);
    cyc("R7 rd", 16'h6000, 0, 0, 1);

    cyc("R5 adv", 16'h6000, 8'h01, 1, 0);
    cyc("R6 adv", 16'h0123, 0, 0, 1);
    cyc("R9 adv", 16'hA456, 0, 0, 1);
    cyc("R5 keep", 16'h7000, 8'h02, 1, 0);
    cyc("R6 adv kept", 16'h3FFF, 0, 0, 1);
    cyc("R5 keep", 16'h6001, 8'hFF, 1, 0);
    cyc("R9 adv kept", 16'hBFFF, 8'h77, 1, 0);
    cyc("R5 simple", 16'h7FFF, 8'h00, 1, 0);
    cyc("R6 simple back", 16'h0123, 0, 0, 1);
    cyc("R9 simple back", 16'hBFFF, 0, 0, 1);

    for (int k = 0; k < 8; k++) begin
      rom_size_sel = 3'(k);
      do_reset();
      cyc("R8 rd", 16'h7ABC, 0, 0, 1);
      cyc("R8 bank", 16'h2000, 8'h1F, 1, 0);
      cyc("R8 hi", 16'h4000, 8'h02, 1, 0);
      cyc("R8 rd", 16'h4ABC, 0, 0, 1);
      cyc("R8 adv", 16'h6000, 8'h01, 1, 0);
      cyc("R8 fixed", 16'h1ABC, 0, 0, 1);
      cyc("R8 bank", 16'h2000, 8'h03, 1, 0);
      cyc("R8 rd", 16'h7FFF, 0, 0, 1);
    end
    rom_size_sel = 3'd6;

    for (int k = 0; k < 8; k++) begin
      ram_size_sel = 3'(k);
      do_reset();
      cyc("R10 pre-enable", 16'hA800, 0, 0, 1);
      cyc("R9 en", 16'h0000, 8'h0A, 1, 0);
      cyc("R9 rd", 16'hBFFF, 0, 0, 1);
      cyc("R9 hi", 16'h4000, 8'h03, 1, 0);
      cyc("R9 adv", 16'h6000, 8'h01, 1, 0);
      cyc("R9 wr", 16'hBABC, 8'h11, 1, 0);
      cyc("R9 rd", 16'hA7FF, 0, 0, 1);
      cyc("R9 hi1", 16'h4000, 8'h01, 1, 0);
      cyc("R9 rd", 16'hA801, 0, 0, 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule